// File: doc/BRIEF.md
# Asymmetric Decode Group Selector

Each clock this block inspects the head of an instruction queue and decides which instructions go to the decoders in that cycle. Every queue entry arrives already pre-decoded: a micro-op count, a flag saying it is a compare-type instruction and a flag saying it is a conditional branch. The decoder slots are not identical. Slot 0 is the complex slot and can take an instruction of up to four micro-ops. Every other slot takes only single-micro-op instructions. A compare followed at once by a conditional branch can be merged into one fused micro-op that fills one slot. Only one such merge is allowed per group.

The choice is made combinationally from the queue head and captured in output registers. The queue gets back a pop count, which is the number of instructions used. Each slot reports a valid flag, a fused flag and its micro-op count. With the default of four slots, the window spans five entries, so a fused pair can fill the last slot. The best case is five instructions delivered as four fused-domain micro-ops.

Top module: `decgrp_selector`

## Requirements
- R1: While rst_n is low at a clock edge, every slot_valid and slot_fused bit and pop_cnt are zero after that edge.
- R2: If stall is high or q_count is zero in a cycle, the next cycle shows no valid slot and a pop_cnt of zero.
- R3: Slot 0 takes an instruction of 1 to 4 micro-ops. Slots 1 and up report only instructions of exactly one micro-op. The micro-op count of entry i sits in q_uops[3i+2:3i], and the count of slot s sits in slot_uops[3s+2:3s]. Entry 0 is the queue head.
- R4: An instruction of more than one micro-op that would fall into slot 1 or later is not decoded, and the group ends just before it.
- R5: An instruction of more than four micro-ops, seen at the head, is decoded alone in slot 0 and reports its full count. It ends the group.
- R6: A single-micro-op compare (q_is_cmp[i]) directly followed by a single-micro-op branch (q_is_br[i+1]) fills one slot. That slot has slot_fused set and a count of 1. A compare followed by anything else, or a compare with more than one micro-op, is decoded on its own.
- R7: At most one slot per group is fused. A later compare-branch pair in the same group is decoded as separate instructions.
- R8: If fusion is still available and a single-micro-op compare is the last visible entry (i+1 >= q_count), it is held back and the group ends before it.
- R9: pop_cnt equals the number of instructions consumed. A fused slot counts as two.
- R10: Valid slots always form a contiguous run starting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_count | input | 3 | Number of valid entries at the queue head (0..5) |
| q_uops | input | 15 | Micro-op count per head entry, 3 bits each, entry 0 lowest |
| q_is_cmp | input | 5 | Compare-type flag per head entry |
| q_is_br | input | 5 | Conditional-branch flag per head entry |
| stall | input | 1 | Downstream stall; nothing is selected |
| pop_cnt | output | 3 | Instructions consumed by the registered group |
| slot_valid | output | 4 | Per-slot valid |
| slot_fused | output | 4 | Per-slot fused compare-and-branch flag |
| slot_uops | output | 12 | Micro-op count per slot, 3 bits each, slot 0 lowest |

## Verification
The assertions assume that every entry below q_count carries a non-zero micro-op count. They also assume that q_count never exceeds the five-entry window. The stimulus table respects both limits in every row: it only uses counts from 1 to 7 in visible entries, and q_count values from 0 to 5. Entries past q_count are filled with harmless values so that any decoding beyond the visible window would show up at the outputs. Two back-to-back rows hold back a lone compare and then release it once its branch arrives.

// File: rtl/decgrp_pkg.sv
// Package: defaults shared by the decode group selector and its checker.
// Assumes a 3-bit micro-op count field per queue entry.
package decgrp_pkg;
    localparam int DEF_SLOTS     = 4;
    localparam int DEF_UOP_W     = 3;
    localparam int DEF_FIRST_MAX = 4;
endpackage

// File: rtl/decgrp_slot_stage.sv
// Module: one decode slot in the selection chain.
// Takes the queue pointer, the stop flag and the fusion-used flag from the
// previous slot, picks this slot's instruction and passes the state on.
// Assumes visible entries have a non-zero micro-op count.
module decgrp_slot_stage #(
    parameter int WINDOW    = 5,
    parameter int UOP_W     = 3,
    parameter int CNT_W     = 3,
    parameter int FIRST_MAX = 4,
    parameter bit IS_FIRST  = 1'b0
) (
    input  logic [CNT_W-1:0]        q_count,
    input  logic [WINDOW*UOP_W-1:0] q_uops,
    input  logic [WINDOW-1:0]       q_is_cmp,
    input  logic [WINDOW-1:0]       q_is_br,
    input  logic [CNT_W-1:0]        ptr_in,
    input  logic                    stop_in,
    input  logic                    fuse_in,
    output logic                    valid_o,
    output logic                    fused_o,
    output logic [UOP_W-1:0]        uops_o,
    output logic [CNT_W-1:0]        ptr_out,
    output logic                    stop_out,
    output logic                    fuse_out
);
    logic [UOP_W-1:0] cur_u, nxt_u;
    logic             cur_c, nxt_b;
    logic             has_cur, has_nxt;
    logic [CNT_W:0]   ptr_nx;

    // Fetch the entry at the pointer and the one just after it.
    always_comb begin
        cur_u = '0;
        nxt_u = '0;
        cur_c = 1'b0;
        nxt_b = 1'b0;
        ptr_nx = {1'b0, ptr_in} + 1'b1;
        for (int i = 0; i < WINDOW; i++) begin
            if ((CNT_W+1)'(i) == {1'b0, ptr_in}) begin
                cur_u = q_uops[i*UOP_W +: UOP_W];
                cur_c = q_is_cmp[i];
            end
            if ((CNT_W+1)'(i) == ptr_nx) begin
                nxt_u = q_uops[i*UOP_W +: UOP_W];
                nxt_b = q_is_br[i];
            end
        end
        has_cur = ptr_in < q_count;
        has_nxt = ptr_nx < {1'b0, q_count};
    end

    // Apply the slot rules: complex first slot, simple later slots, one fusion.
    always_comb begin
        valid_o  = 1'b0;
        fused_o  = 1'b0;
        uops_o   = '0;
        ptr_out  = ptr_in;
        stop_out = stop_in;
        fuse_out = fuse_in;
        if (!stop_in) begin
            if (!has_cur) begin
                stop_out = 1'b1;
            end else if (IS_FIRST && cur_u > UOP_W'(FIRST_MAX)) begin
                valid_o  = 1'b1;
                uops_o   = cur_u;
                ptr_out  = ptr_in + 1'b1;
                stop_out = 1'b1;
            end else if (!IS_FIRST && cur_u != UOP_W'(1)) begin
                stop_out = 1'b1;
            end else if (cur_c && cur_u == UOP_W'(1) && !fuse_in) begin
                if (!has_nxt) begin
                    stop_out = 1'b1;
                end else if (nxt_b && nxt_u == UOP_W'(1)) begin
                    valid_o  = 1'b1;
                    fused_o  = 1'b1;
                    uops_o   = UOP_W'(1);
                    ptr_out  = ptr_in + CNT_W'(2);
                    fuse_out = 1'b1;
                end else begin
                    valid_o = 1'b1;
                    uops_o  = cur_u;
                    ptr_out = ptr_in + 1'b1;
                end
            end else begin
                valid_o = 1'b1;
                uops_o  = cur_u;
                ptr_out = ptr_in + 1'b1;
            end
        end
    end
endmodule

// File: rtl/decgrp_out_reg.sv
// Module: output register bank for the selected decode group.
// Assumes a synchronous active-low reset that clears every output.
module decgrp_out_reg #(
    parameter int NUM_SLOTS = 4,
    parameter int UOP_W     = 3,
    parameter int CNT_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS-1:0]       d_valid,
    input  logic [NUM_SLOTS-1:0]       d_fused,
    input  logic [NUM_SLOTS*UOP_W-1:0] d_uops,
    input  logic [CNT_W-1:0]           d_pop,
    output logic [NUM_SLOTS-1:0]       q_valid,
    output logic [NUM_SLOTS-1:0]       q_fused,
    output logic [NUM_SLOTS*UOP_W-1:0] q_uops,
    output logic [CNT_W-1:0]           q_pop
);
    // Capture the combinational choice once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= '0;
            q_fused <= '0;
            q_uops  <= '0;
            q_pop   <= '0;
        end else begin
            q_valid <= d_valid;
            q_fused <= d_fused;
            q_uops  <= d_uops;
            q_pop   <= d_pop;
        end
    end
endmodule

// File: rtl/decgrp_selector.sv
// Module: top of the asymmetric decode group selector.
// Chains one stage per slot. Slot 0 is the only complex slot. The window is
// one entry wider than the slot count, so the last slot can hold a fused pair.
// Assumes q_count <= NUM_SLOTS+1 and non-zero counts in visible entries.
module decgrp_selector
    import decgrp_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int UOP_W     = DEF_UOP_W,
    parameter int FIRST_MAX = DEF_FIRST_MAX,
    localparam int WINDOW   = NUM_SLOTS + 1,
    localparam int CNT_W    = $clog2(WINDOW + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           q_count,
    input  logic [WINDOW*UOP_W-1:0]    q_uops,
    input  logic [WINDOW-1:0]          q_is_cmp,
    input  logic [WINDOW-1:0]          q_is_br,
    input  logic                       stall,
    output logic [CNT_W-1:0]           pop_cnt,
    output logic [NUM_SLOTS-1:0]       slot_valid,
    output logic [NUM_SLOTS-1:0]       slot_fused,
    output logic [NUM_SLOTS*UOP_W-1:0] slot_uops
);
    logic [CNT_W-1:0]           ptr_c  [NUM_SLOTS+1];
    logic                       stop_c [NUM_SLOTS+1];
    logic                       fuse_c [NUM_SLOTS+1];
    logic [NUM_SLOTS-1:0]       sel_valid;
    logic [NUM_SLOTS-1:0]       sel_fused;
    logic [NUM_SLOTS*UOP_W-1:0] sel_uops;

    // Seed the chain; a stall stops it before slot 0.
    always_comb begin
        ptr_c[0]  = '0;
        stop_c[0] = stall;
        fuse_c[0] = 1'b0;
    end

    for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
        decgrp_slot_stage #(
            .WINDOW   (WINDOW),
            .UOP_W    (UOP_W),
            .CNT_W    (CNT_W),
            .FIRST_MAX(FIRST_MAX),
            .IS_FIRST (gs == 0)
        ) u_stage (
            .q_count (q_count),
            .q_uops  (q_uops),
            .q_is_cmp(q_is_cmp),
            .q_is_br (q_is_br),
            .ptr_in  (ptr_c[gs]),
            .stop_in (stop_c[gs]),
            .fuse_in (fuse_c[gs]),
            .valid_o (sel_valid[gs]),
            .fused_o (sel_fused[gs]),
            .uops_o  (sel_uops[gs*UOP_W +: UOP_W]),
            .ptr_out (ptr_c[gs+1]),
            .stop_out(stop_c[gs+1]),
            .fuse_out(fuse_c[gs+1])
        );
    end

    decgrp_out_reg #(
        .NUM_SLOTS(NUM_SLOTS),
        .UOP_W    (UOP_W),
        .CNT_W    (CNT_W)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_valid(sel_valid),
        .d_fused(sel_fused),
        .d_uops (sel_uops),
        .d_pop  (ptr_c[NUM_SLOTS]),
        .q_valid(slot_valid),
        .q_fused(slot_fused),
        .q_uops (slot_uops),
        .q_pop  (pop_cnt)
    );
endmodule

// File: rtl/decgrp_selector_chk.sv
// Module: property checker for decgrp_selector, attached with bind below.
// Assumes the same parameters as the module it watches.
module decgrp_selector_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int UOP_W     = 3,
    parameter int FIRST_MAX = 4,
    localparam int WINDOW   = NUM_SLOTS + 1,
    localparam int CNT_W    = $clog2(WINDOW + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [CNT_W-1:0]           q_count,
    input logic [WINDOW*UOP_W-1:0]    q_uops,
    input logic                       stall,
    input logic [CNT_W-1:0]           pop_cnt,
    input logic [NUM_SLOTS-1:0]       slot_valid,
    input logic [NUM_SLOTS-1:0]       slot_fused,
    input logic [NUM_SLOTS*UOP_W-1:0] slot_uops
);
    // Input assumption: every visible entry has a non-zero count.
    function automatic logic visible_nonzero(input logic [CNT_W-1:0] cnt,
                                             input logic [WINDOW*UOP_W-1:0] u);
        logic ok = 1'b1;
        for (int i = 0; i < WINDOW; i++)
            if (CNT_W'(i) < cnt && u[i*UOP_W +: UOP_W] == '0) ok = 1'b0;
        return ok;
    endfunction

    p_uops_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        visible_nonzero(q_count, q_uops) && q_count <= CNT_W'(WINDOW));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (slot_valid == '0 && slot_fused == '0 && pop_cnt == '0));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || q_count == '0) |=> (slot_valid == '0 && pop_cnt == '0));

    for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_simple
        p_simple_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[s] |-> slot_uops[s*UOP_W +: UOP_W] == UOP_W'(1));
    end

    p_microcode_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid[0] && slot_uops[UOP_W-1:0] > UOP_W'(FIRST_MAX))
        |-> (slot_valid >> 1) == '0);

    p_one_fusion_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_fused) <= 1);

    p_fused_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fused & ~slot_valid) == '0);

    p_pop_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_cnt) == $countones(slot_valid) + $countones(slot_fused));

    p_pop_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pop_cnt <= $past(q_count));

    p_prefix_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_SLOTS'(slot_valid + 1'b1) & slot_valid) == '0);
endmodule

bind decgrp_selector decgrp_selector_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .UOP_W    (UOP_W),
    .FIRST_MAX(FIRST_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_count   (q_count),
    .q_uops    (q_uops),
    .stall     (stall),
    .pop_cnt   (pop_cnt),
    .slot_valid(slot_valid),
    .slot_fused(slot_fused),
    .slot_uops (slot_uops)
);

// File: tb/decgrp_selector_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed reset checks.
module decgrp_selector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  q_count = '0;
    logic [14:0] q_uops = '0;
    logic [4:0]  q_is_cmp = '0;
    logic [4:0]  q_is_br = '0;
    logic        stall = 1'b0;
    logic [2:0]  pop_cnt;
    logic [3:0]  slot_valid;
    logic [3:0]  slot_fused;
    logic [11:0] slot_uops;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    decgrp_selector dut_i (
        .clk(clk), .rst_n(rst_n), .q_count(q_count), .q_uops(q_uops),
        .q_is_cmp(q_is_cmp), .q_is_br(q_is_br), .stall(stall),
        .pop_cnt(pop_cnt), .slot_valid(slot_valid),
        .slot_fused(slot_fused), .slot_uops(slot_uops)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic [2:0]  cnt;
        logic [14:0] u;
        logic [4:0]  c;
        logic [4:0]  b;
        logic        st;
        logic [2:0]  pop;
        logic [3:0]  v;
        logic [3:0]  f;
        logic [11:0] eu;
    } vec_t;

    localparam logic [14:0] ALL1 = {3'd1, 3'd1, 3'd1, 3'd1, 3'd1};
    localparam logic [11:0] EU1  = {3'd1, 3'd1, 3'd1, 3'd1};
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{"R3", 3'd5, ALL1, 5'b00000, 5'b00000, 1'b0, 3'd4, 4'b1111, 4'b0000, EU1},
        '{"R3", 3'd5, {3'd1,3'd1,3'd1,3'd1,3'd4}, 5'b0, 5'b0, 1'b0, 3'd4, 4'b1111, 4'b0, {3'd1,3'd1,3'd1,3'd4}},
        '{"R4", 3'd5, {3'd1,3'd1,3'd1,3'd2,3'd1}, 5'b0, 5'b0, 1'b0, 3'd1, 4'b0001, 4'b0, {3'd0,3'd0,3'd0,3'd1}},
        '{"R5", 3'd5, {3'd1,3'd1,3'd1,3'd1,3'd6}, 5'b0, 5'b0, 1'b0, 3'd1, 4'b0001, 4'b0, {3'd0,3'd0,3'd0,3'd6}},
        '{"R6", 3'd5, ALL1, 5'b01000, 5'b10000, 1'b0, 3'd5, 4'b1111, 4'b1000, EU1},
        '{"R7", 3'd5, ALL1, 5'b00101, 5'b01010, 1'b0, 3'd5, 4'b1111, 4'b0001, EU1},
        '{"R8", 3'd3, ALL1, 5'b00100, 5'b00000, 1'b0, 3'd2, 4'b0011, 4'b0, {3'd0,3'd0,3'd1,3'd1}},
        '{"R8", 3'd1, ALL1, 5'b00001, 5'b00000, 1'b0, 3'd0, 4'b0000, 4'b0, 12'd0},
        '{"R2", 3'd5, ALL1, 5'b00000, 5'b00000, 1'b1, 3'd0, 4'b0000, 4'b0, 12'd0},
        '{"R2", 3'd0, ALL1, 5'b00000, 5'b00000, 1'b0, 3'd0, 4'b0000, 4'b0, 12'd0},
        '{"R6", 3'd5, ALL1, 5'b00001, 5'b00000, 1'b0, 3'd4, 4'b1111, 4'b0, EU1},
        '{"R4", 3'd5, {3'd1,3'd1,3'd3,3'd1,3'd1}, 5'b00001, 5'b00010, 1'b0, 3'd2, 4'b0001, 4'b0001, {3'd0,3'd0,3'd0,3'd1}},
        '{"R9", 3'd2, ALL1, 5'b00000, 5'b00000, 1'b0, 3'd2, 4'b0011, 4'b0, {3'd0,3'd0,3'd1,3'd1}},
        '{"R6", 3'd5, {3'd1,3'd1,3'd1,3'd1,3'd2}, 5'b00001, 5'b00010, 1'b0, 3'd4, 4'b1111, 4'b0, {3'd1,3'd1,3'd1,3'd2}},
        '{"R8", 3'd4, ALL1, 5'b01000, 5'b00000, 1'b0, 3'd3, 4'b0111, 4'b0, {3'd0,3'd1,3'd1,3'd1}},
        '{"R7", 3'd5, ALL1, 5'b10001, 5'b00010, 1'b0, 3'd5, 4'b1111, 4'b0001, EU1},
        '{"R8", 3'd1, ALL1, 5'b00001, 5'b00000, 1'b0, 3'd0, 4'b0000, 4'b0, 12'd0},
        '{"R8", 3'd2, ALL1, 5'b00001, 5'b00010, 1'b0, 3'd2, 4'b0001, 4'b0001, {3'd0,3'd0,3'd0,3'd1}}
    };

    task automatic chk(input logic [15:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        q_count  = v.cnt;
        q_uops   = v.u;
        q_is_cmp = v.c;
        q_is_br  = v.b;
        stall    = v.st;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        drive(VECS[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs clear while reset is held, even with a full queue.
        chk("R1", "valid", 32'(slot_valid), 32'd0);
        chk("R1", "pop", 32'(pop_cnt), 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k]);
            @(posedge clk);
            @(negedge clk);
            chk(VECS[k].tag, "pop", 32'(pop_cnt), 32'(VECS[k].pop));
            chk(VECS[k].tag, "valid", 32'(slot_valid), 32'(VECS[k].v));
            chk(VECS[k].tag, "fused", 32'(slot_fused), 32'(VECS[k].f));
            chk(VECS[k].tag, "uops", 32'(slot_uops), 32'(VECS[k].eu));
        end
        // R1: reset in the middle of traffic clears a loaded group.
        drive(VECS[4]);
        @(posedge clk);
        @(negedge clk);
        chk("R6", "fused", 32'(slot_fused), 32'h8);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "valid", 32'(slot_valid), 32'd0);
        chk("R1", "fused", 32'(slot_fused), 32'd0);
        chk("R1", "pop", 32'(pop_cnt), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "pop", 32'(pop_cnt), 32'd5);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule